// File: doc/BRIEF.md
# Pin Bank with Timer Wave Merging

This block controls a small set of general-purpose pins. There are two 4-bit ports (A and B) and one 1-bit port (C). Each pin has an output latch and a direction bit. The pads themselves are outside this block: it drives logic-level output value, output-enable and pull-up-enable signals toward them, and receives each pad's input level. On port A, the lowest pins (three by default) can also carry square waves from timers. A timer wave reaches a pin when that pin is in output mode, and it only shows through while the pin's latch holds 0.

Software reaches the bank through a request channel using valid/ready. `req_ready` is tied high, so the block never applies back-pressure: every request offered with `req_valid` is taken on that clock edge. Each accepted read returns exactly one response on the following cycle. The response channel has no ready signal, so the consumer must take it in that cycle. Writes return no response. An access covers either a whole port or a single bit, which is picked by `req_bit_sel`. No access spans two ports.

Top module: `gpio_tmr_bank`

## Requirements
- R1: After reset, every latch, direction bit and pull-up control is 0, so all pad output, output-enable and pull-up-enable signals are 0 and every pin is an input.
- R2: Ports A and B have one direction bit per pin, with 1 meaning output. `pad_*_oe` follows the direction register bit for bit.
- R3: A port A pin below TMR_N drives `dir & (latch | tmr_wave)`. Every other pin drives `dir & latch`, so a pin in input mode drives 0.
- R4: Ports A and B each have a single pull-up control, stored from `req_wdata[0]`, that covers all four pins. Port C has its own pull-up bit. A pin's `pad_*_pu` is 1 only while its pull-up is on and the pin is in input mode.
- R5: `req_addr[3:2]` selects the port (0 = A, 1 = B, 2 = C) and `req_addr[1:0]` selects the register (0 = data latch, 1 = direction, 2 = pull-up). Writes to any other address change nothing, and reads of any other address return 0.
- R6: With `req_bit` = 0, a write loads `req_wdata` into the port's bits. With `req_bit` = 1, only bit `req_bit_sel` is loaded, from `req_wdata[0]`. A bit select beyond the port's width (or any select other than 0 for a grouped pull-up) has no effect.
- R7: A read of the data register returns, for each pin, the latch if the pin is in output mode, or the pad level after SYNC_STAGES flip-flops if it is in input mode. A single-bit read returns the selected bit in `rsp_rdata[0]`, with the upper bits 0.
- R8: `req_ready` is always 1. A read accepted at an edge sets `rsp_valid` and `rsp_rdata` at that same edge. `rsp_valid` is 0 after any cycle that held no read. Direction reads return the stored bits, and pull-up reads of ports A and B return the control in bit 0.
- R9: On a timer pin in output mode, a latch value of 1 forces the pin high regardless of the timer wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Port select [3:2], register select [1:0] |
| req_bit | input | 1 | 1 = single-bit access |
| req_bit_sel | input | 2 | Bit index for single-bit access |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 4 | Read response data |
| tmr_wave | input | TMR_N | Timer square waves for port A low pins |
| pad_a_in | input | 4 | Port A pad levels |
| pad_a_out | output | 4 | Port A drive values |
| pad_a_oe | output | 4 | Port A output enables |
| pad_a_pu | output | 4 | Port A pull-up enables |
| pad_b_in | input | 4 | Port B pad levels |
| pad_b_out | output | 4 | Port B drive values |
| pad_b_oe | output | 4 | Port B output enables |
| pad_b_pu | output | 4 | Port B pull-up enables |
| pad_c_in | input | 1 | Port C pad level |
| pad_c_out | output | 1 | Port C drive value |
| pad_c_oe | output | 1 | Port C output enable |
| pad_c_pu | output | 1 | Port C pull-up enable |

## Verification
The bench uses the default parameters: three timer pins on port A and a two-stage input synchronizer. With three timer pins, bit 3 of port A is an ordinary pin, so the bench can check both the merged and the plain output paths on the same port. With two synchronizer stages, a pad change shows up in data reads after a short, known delay. Port C's 1-bit width lets the bench try out-of-range bit selects, and the grouped pull-up on port B can be compared with the per-pin output enables.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 4;
  localparam int SEL_W  = $clog2(NIB_W);

  typedef enum logic [1:0] {
    PORT_A    = 2'd0,
    PORT_B    = 2'd1,
    PORT_C    = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_NONE = 2'd3
  } reg_e;

  typedef struct packed {
    logic lat;
    logic dir;
    logic pull;
  } wr_sel_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_group.sv
module gpio_pin_group
  import gpio_bank_pkg::*;
#(
  parameter int W           = 4,
  parameter bit PU_PER_BIT  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_sel_t      wsel,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] tmr,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] rd_pins,
  output logic [W-1:0] rd_dir,
  output logic [W-1:0] rd_pu
);
  localparam int PU_W = PU_PER_BIT ? W : 1;

  logic [W-1:0]    lat_q, dir_q, pin_sync, pu_vec;
  logic [PU_W-1:0] pu_q;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
      pu_q  <= '0;
    end else begin
      if (wsel.lat)  lat_q <= (lat_q & ~wmask) | (wdata & wmask);
      if (wsel.dir)  dir_q <= (dir_q & ~wmask) | (wdata & wmask);
      if (wsel.pull) pu_q  <= (pu_q & ~wmask[PU_W-1:0]) | (wdata[PU_W-1:0] & wmask[PU_W-1:0]);
    end
  end

  generate
    if (PU_PER_BIT) begin : g_pu_bit
      assign pu_vec = pu_q;
      assign rd_pu  = pu_q;
    end else begin : g_pu_grp
      assign pu_vec = {W{pu_q[0]}};
      always_comb begin
        rd_pu    = '0;
        rd_pu[0] = pu_q[0];
      end
    end
  endgenerate

  assign pad_out = dir_q & (lat_q | tmr);
  assign pad_oe  = dir_q;
  assign pad_pu  = pu_vec & ~dir_q;
  assign rd_pins = (dir_q & lat_q) | (~dir_q & pin_sync);
  assign rd_dir  = dir_q;

  // R1: state is clear right after reset release
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lat_q == '0 && dir_q == '0 && pu_q == '0));
  // R6: latch changes only on a latch write
  a_r6_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel.lat |=> $stable(lat_q));
  // R2: direction changes only on a direction write
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel.dir |=> $stable(dir_q));
  // R4: pull-up control changes only on a pull-up write
  a_r4_pu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel.pull |=> $stable(pu_q));
endmodule

// File: rtl/gpio_tmr_bank.sv
module gpio_tmr_bank
  import gpio_bank_pkg::*;
#(
  parameter int TMR_N       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_bit,
  input  logic [SEL_W-1:0]    req_bit_sel,
  input  logic [NIB_W-1:0]    req_wdata,
  output logic                rsp_valid,
  output logic [NIB_W-1:0]    rsp_rdata,
  input  logic [TMR_N-1:0]    tmr_wave,
  input  logic [NIB_W-1:0]    pad_a_in,
  output logic [NIB_W-1:0]    pad_a_out,
  output logic [NIB_W-1:0]    pad_a_oe,
  output logic [NIB_W-1:0]    pad_a_pu,
  input  logic [NIB_W-1:0]    pad_b_in,
  output logic [NIB_W-1:0]    pad_b_out,
  output logic [NIB_W-1:0]    pad_b_oe,
  output logic [NIB_W-1:0]    pad_b_pu,
  input  logic                pad_c_in,
  output logic                pad_c_out,
  output logic                pad_c_oe,
  output logic                pad_c_pu
);
  port_e            psel;
  reg_e             rsel;
  logic [NIB_W-1:0] lane_mask, lane_data, tmr_a, rd_nib, rd_val;
  wr_sel_t          ws_a, ws_b, ws_c;
  logic [NIB_W-1:0] a_pins, a_dir, a_pu, b_pins, b_dir, b_pu;
  logic [0:0]       c_pins, c_dir, c_pu;
  logic             rd_go;

  assign req_ready = 1'b1;
  assign psel  = port_e'(req_addr[3:2]);
  assign rsel  = reg_e'(req_addr[1:0]);
  assign rd_go = req_valid && !req_write;

  assign lane_mask = req_bit ? (NIB_W'(1) << req_bit_sel) : {NIB_W{1'b1}};
  assign lane_data = req_bit ? {NIB_W{req_wdata[0]}} : req_wdata;

  always_comb begin
    tmr_a = '0;
    for (int i = 0; i < TMR_N; i++) tmr_a[i] = tmr_wave[i];
  end

  function automatic wr_sel_t decode_wr(input logic hit, input reg_e r);
    wr_sel_t w;
    w.lat  = hit && (r == REG_DATA);
    w.dir  = hit && (r == REG_DIR);
    w.pull = hit && (r == REG_PULL);
    return w;
  endfunction

  always_comb begin
    ws_a = decode_wr(req_valid && req_write && psel == PORT_A, rsel);
    ws_b = decode_wr(req_valid && req_write && psel == PORT_B, rsel);
    ws_c = decode_wr(req_valid && req_write && psel == PORT_C, rsel);
  end

  gpio_pin_group #(.W(NIB_W), .PU_PER_BIT(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_port_a (
    .clk(clk), .rst_n(rst_n), .wsel(ws_a), .wmask(lane_mask), .wdata(lane_data),
    .tmr(tmr_a), .pad_in(pad_a_in), .pad_out(pad_a_out), .pad_oe(pad_a_oe),
    .pad_pu(pad_a_pu), .rd_pins(a_pins), .rd_dir(a_dir), .rd_pu(a_pu)
  );

  gpio_pin_group #(.W(NIB_W), .PU_PER_BIT(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_port_b (
    .clk(clk), .rst_n(rst_n), .wsel(ws_b), .wmask(lane_mask), .wdata(lane_data),
    .tmr('0), .pad_in(pad_b_in), .pad_out(pad_b_out), .pad_oe(pad_b_oe),
    .pad_pu(pad_b_pu), .rd_pins(b_pins), .rd_dir(b_dir), .rd_pu(b_pu)
  );

  gpio_pin_group #(.W(1), .PU_PER_BIT(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_port_c (
    .clk(clk), .rst_n(rst_n), .wsel(ws_c), .wmask(lane_mask[0:0]), .wdata(lane_data[0:0]),
    .tmr(1'b0), .pad_in(pad_c_in), .pad_out(pad_c_out), .pad_oe(pad_c_oe),
    .pad_pu(pad_c_pu), .rd_pins(c_pins), .rd_dir(c_dir), .rd_pu(c_pu)
  );

  always_comb begin
    rd_nib = '0;
    case (psel)
      PORT_A: case (rsel)
        REG_DATA: rd_nib = a_pins;
        REG_DIR:  rd_nib = a_dir;
        REG_PULL: rd_nib = a_pu;
        default:  rd_nib = '0;
      endcase
      PORT_B: case (rsel)
        REG_DATA: rd_nib = b_pins;
        REG_DIR:  rd_nib = b_dir;
        REG_PULL: rd_nib = b_pu;
        default:  rd_nib = '0;
      endcase
      PORT_C: case (rsel)
        REG_DATA: rd_nib = {{(NIB_W-1){1'b0}}, c_pins};
        REG_DIR:  rd_nib = {{(NIB_W-1){1'b0}}, c_dir};
        REG_PULL: rd_nib = {{(NIB_W-1){1'b0}}, c_pu};
        default:  rd_nib = '0;
      endcase
      default: rd_nib = '0;
    endcase
    rd_val = req_bit ? {{(NIB_W-1){1'b0}}, rd_nib[req_bit_sel]} : rd_nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      rsp_rdata <= rd_go ? rd_val : '0;
    end
  end

  // R8: every accepted read yields a response next cycle
  a_r8_read_responds: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);
  // R8: no response without a read
  a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !rsp_valid);
  // R3: a driven-low timer pin in output mode implies the wave is low
  a_r3_timer_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_a_oe[0] && !pad_a_out[0]) |-> !tmr_a[0]);
endmodule

// File: tb/sim_gpio_tmr_bank.sv
module sim_gpio_tmr_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_bit = 1'b0;
  logic       req_ready;
  logic [3:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_bit_sel = '0;
  logic       rsp_valid;
  logic [3:0] rsp_rdata;
  logic [2:0] tmr_wave = '0;
  logic [3:0] pad_a_in = '0, pad_b_in = '0;
  logic [3:0] pad_a_out, pad_a_oe, pad_a_pu, pad_b_out, pad_b_oe, pad_b_pu;
  logic       pad_c_in = 1'b0, pad_c_out, pad_c_oe, pad_c_pu;

  int n_chk = 0, n_bad = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_tmr_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_bit(req_bit),
    .req_bit_sel(req_bit_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .tmr_wave(tmr_wave),
    .pad_a_in(pad_a_in), .pad_a_out(pad_a_out), .pad_a_oe(pad_a_oe), .pad_a_pu(pad_a_pu),
    .pad_b_in(pad_b_in), .pad_b_out(pad_b_out), .pad_b_oe(pad_b_oe), .pad_b_pu(pad_b_pu),
    .pad_c_in(pad_c_in), .pad_c_out(pad_c_out), .pad_c_oe(pad_c_oe), .pad_c_pu(pad_c_pu)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic b, input logic [1:0] s, input logic [3:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_bit = b; req_bit_sel = s; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic b, input logic [1:0] s,
                    input logic [3:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_bit = b; req_bit_sel = s;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R8: actual unexpected response %h expected none", rsp_rdata);
      end else begin
        automatic logic [3:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 pads after reset",
        {pad_a_out, pad_a_oe, pad_a_pu}, 12'h000);
    #2 rst_n = 1'b1;
    idle(1);
    chk("R1 port A pads", {pad_a_out, pad_a_oe, pad_a_pu}, 12'h000);
    chk("R1 port B pads", {pad_b_out, pad_b_oe, pad_b_pu}, 12'h000);
    chk("R1 port C pads", {9'd0, pad_c_out, pad_c_oe, pad_c_pu}, 12'h000);
    chk("R8 ready high", {11'd0, req_ready}, 12'h001);
    rd(4'h1, 0, 0, 4'h0, "R1 dir A read");

    // R2 per-pin direction
    wr(4'h1, 0, 0, 4'b1010);
    chk("R2 oe follows dir", {8'd0, pad_a_oe}, {8'd0, 4'b1010});
    rd(4'h1, 0, 0, 4'b1010, "R8 dir A readback");

    // R3 timer merge
    wr(4'h1, 0, 0, 4'b0111);
    wr(4'h0, 0, 0, 4'b0000);
    tmr_wave = 3'b101; #1;
    chk("R3 timer shows", {8'd0, pad_a_out}, {8'd0, 4'b0101});
    tmr_wave = 3'b010; #1;
    chk("R3 timer follows", {8'd0, pad_a_out}, {8'd0, 4'b0010});
    wr(4'h0, 0, 0, 4'b0001);
    chk("R9 latch masks timer", {8'd0, pad_a_out}, {8'd0, 4'b0011});
    tmr_wave = 3'b000; #1;
    chk("R9 latch holds high", {8'd0, pad_a_out}, {8'd0, 4'b0001});
    wr(4'h0, 0, 0, 4'b1001);
    chk("R3 input pin drives 0", {8'd0, pad_a_out}, {8'd0, 4'b0001});
    wr(4'h1, 0, 0, 4'b1111);
    chk("R3 plain pin 3", {8'd0, pad_a_out}, {8'd0, 4'b1001});

    // R4 pull-ups
    wr(4'h2, 0, 0, 4'b0001);
    chk("R4 pull off in output", {8'd0, pad_a_pu}, 12'h000);
    wr(4'h1, 0, 0, 4'b0011);
    chk("R4 grouped pull A", {8'd0, pad_a_pu}, {8'd0, 4'b1100});
    rd(4'h2, 0, 0, 4'b0001, "R8 pull A readback");
    wr(4'h6, 0, 0, 4'b0001);
    chk("R4 grouped pull B", {8'd0, pad_b_pu}, {8'd0, 4'b1111});
    wr(4'hA, 0, 0, 4'b0001);
    chk("R4 pull C on", {11'd0, pad_c_pu}, 12'h001);
    wr(4'h9, 0, 0, 4'b0001);
    chk("R4 pull C gated by dir", {10'd0, pad_c_pu, pad_c_oe}, 12'h001);

    // R6 bit access
    wr(4'h4, 0, 0, 4'b0101);
    wr(4'h4, 1, 1, 4'b0001);
    wr(4'h5, 0, 0, 4'b1111);
    chk("R6 bit write latch B", {8'd0, pad_b_out}, {8'd0, 4'b0111});
    wr(4'h5, 1, 3, 4'b0000);
    chk("R6 bit write dir B", {4'd0, pad_b_oe, pad_b_pu}, {4'd0, 4'b0111, 4'b1000});
    wr(4'h8, 1, 2, 4'b0001);
    chk("R6 out-of-range bit on C", {11'd0, pad_c_out}, 12'h000);
    wr(4'h8, 1, 0, 4'b0001);
    chk("R6 bit 0 on C", {11'd0, pad_c_out}, 12'h001);
    wr(4'h2, 1, 2, 4'b0000);
    chk("R6 grouped pull ignores bit 2", {8'd0, pad_a_pu}, {8'd0, 4'b1100});

    // R7 pin reads
    wr(4'h5, 0, 0, 4'b0011);
    pad_b_in = 4'b1010;
    idle(3);
    rd(4'h4, 0, 0, 4'b1011, "R7 mixed read B");
    rd(4'h4, 1, 3, 4'b0001, "R7 bit read B3");
    rd(4'h4, 1, 2, 4'b0000, "R7 bit read B2");
    rd(4'h8, 0, 0, 4'b0001, "R7 C output latch");
    wr(4'h9, 0, 0, 4'b0000);
    pad_c_in = 1'b1;
    idle(3);
    rd(4'h8, 0, 0, 4'b0001, "R7 C pad high");
    pad_c_in = 1'b0;
    idle(3);
    rd(4'h8, 0, 0, 4'b0000, "R7 C pad low");

    // R5 unmapped addresses
    wr(4'h3, 0, 0, 4'b1111);
    wr(4'hC, 0, 0, 4'b1111);
    wr(4'hF, 0, 0, 4'b1111);
    chk("R5 port A unchanged", {4'd0, pad_a_out, pad_a_oe}, {4'd0, 4'b0001, 4'b0011});
    chk("R5 port B unchanged", {4'd0, pad_b_out, pad_b_oe}, {4'd0, 4'b0011, 4'b0011});
    chk("R5 port C unchanged", {9'd0, pad_c_out, pad_c_oe, pad_c_pu}, 12'h001);
    rd(4'h3, 0, 0, 4'h0, "R5 read unmapped reg");
    rd(4'hD, 0, 0, 4'h0, "R5 read unmapped port");

    idle(3);
    chk("R8 all responses seen", exp_q.size(), 12'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule